// File: doc/BRIEF.md
# Extended Error Register Dump Sequencer

This block gathers a unit's diagnostic registers after a fault. A start pulse and a unit ID begin a dump. The sequencer masters a simple 64-bit register bus and reads what it needs. It turns every value it collects into a record holding the address, an index and the value, and sends each record out on a valid/ready stream.

A dump has two phases. In the first phase a pointer register gives the location of an in-memory chain of dump descriptors. Each descriptor asks for one of two reads: the same register read several times, or a run of consecutive registers. In the second phase the sequencer visits eight trace rings. For each ring it reads a ring map. For every trap or trace that the map reports, it writes a selector register and then drains a mailbox register.

A busy flag covers the whole dump. A one-cycle done pulse marks the end, and a record counter reports how many records left the block. The register file being dumped is outside the block, and so is the store that keeps the records.

Top module: `regdump_seq`

## Requirements
- R1: Every bus address is the unit ID shifted left by 24 bits, ORed with a register offset. The unit ID is latched at start. The first access of a dump is a read of the pointer register at offset 0x10.
- R2: A pointer value of 0 or all ones means there is no descriptor chain. In that case the next access is the ring map read for ring 0 (offset 0x100).
- R3: Otherwise descriptors are read starting at the pointer's low 24 bits (ORed with the unit offset), stepping by 8. The walk stops at the first descriptor that reads 0 or all ones. In a descriptor, bit 39 is the mode, bits 38:24 are the length and bits 23:0 are the target offset.
- R4: Repeat mode (bit 39 = 1) reads the target address `length` times. Each record has index 0, 1, 2 and so on.
- R5: Sequential mode (bit 39 = 0) treats the length as a byte count. It reads length/8 addresses, starting at the target and stepping by 8, with index 0. A length below 8 produces no reads.
- R6: Rings 0 to 7 are handled in order. The map for a ring is read at offset 0x100 + 8*ring. A map of 0 or all ones skips the ring. Otherwise bits 31:24 give the trap count, bits 23:16 the trace count and bits 15:0 the entries per trace.
- R7: For each trace number t from 0 up to the trace count, the selector (ring in bits 7:4, t in bits 3:0) is written to offset 0x180. Only after that write is the mailbox read. Trace 0 reads the mailbox trap-count times and the other traces read it entries-per-trace times. A count of 0 still writes the selector but reads nothing.
- R8: A mailbox record has the mailbox address (offset 0x188). Its index is the selector shifted left 16 bits, ORed with the entry number.
- R9: A record keeps valid, address, index and value stable while not accepted. Under back-pressure no record is lost or duplicated.
- R10: The bus never asserts read and write together. A request holds its address (and write data) unchanged until the cycle in which the acknowledge is seen.
- R11: Busy rises in the cycle after an accepted start and stays high until done. Done pulses for one cycle, with busy low, only after the last record has been accepted. A start while busy is ignored.
- R12: The record counter clears at an accepted start, counts every accepted record and holds its final value after done.
- R13: After reset, busy, done, record valid and both bus requests are low and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken when idle |
| unit_id | input | 4 | Unit to dump |
| busy | output | 1 | Dump in progress |
| done | output | 1 | One-cycle end-of-dump pulse |
| rec_count | output | 32 | Records accepted in this dump |
| bus_rd | output | 1 | Register read request |
| bus_wr | output | 1 | Register write request |
| bus_addr | output | 32 | Register byte address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Request completed; read data valid |
| bus_rdata | input | 64 | Read data |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Downstream accepts the record |
| rec_addr | output | 32 | Record source address |
| rec_idx | output | 32 | Record index |
| rec_val | output | 64 | Record value |

## Verification
The output register can hand a record downstream in the same cycle that the sequencer pushes the next one. The bench provokes this by holding ready high for one dump and waving it in two duty patterns for the others, while bus latency varies from zero to two cycles. The scoreboard then requires each record exactly once, in order, with the held-value check catching any change during a stall. The second overlap is a start pulse given while busy, with a different unit ID. It is judged by the unchanged record stream and the unchanged count.

// File: rtl/regdump_pkg.sv
// Shared types and helpers for the register dump sequencer.
// Assumes descriptor and ring map layouts fixed by the register block.
package regdump_pkg;

    // Selector field widths: ring above trace
    localparam int SEL_TRACE_W = 4;
    localparam int SEL_RING_W  = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_PTR, S_DESC, S_DATA, S_RMAP, S_SEL, S_MBX, S_PUSH, S_FIN
    } seq_state_t;

    // Descriptor word bits 39:0
    typedef struct packed {
        logic        mode;   // 1: repeat same address
        logic [14:0] len;    // count (repeat) or bytes (sequential)
        logic [23:0] tgt;    // target offset
    } dump_desc_t;

    // Ring map word bits 31:0
    typedef struct packed {
        logic [7:0]  traps;
        logic [7:0]  traces;
        logic [15:0] entries;
    } ring_map_t;

    // Selector value for a ring/trace pair
    function automatic logic [31:0] make_sel(input logic [7:0] ring, input logic [7:0] trace);
        logic [31:0] r_part;
        logic [31:0] t_part;
        r_part = 32'(ring  & 8'((1 << SEL_RING_W) - 1));
        t_part = 32'(trace & 8'((1 << SEL_TRACE_W) - 1));
        return (r_part << SEL_TRACE_W) | t_part;
    endfunction

endpackage

// File: rtl/regdump_decode.sv
// Combinational decode of a 64-bit read word as an end marker,
// a dump descriptor and a ring map. Assumes word is the current bus read data.
module regdump_decode
    import regdump_pkg::*;
(
    input  logic [63:0] word,
    output logic        blank,
    output dump_desc_t  desc,
    output logic [15:0] desc_reads,
    output ring_map_t   rmap
);

    // End/skip marker: all zeros or all ones
    always_comb blank = (word == 64'd0) || (&word);

    // Field split and read count for the descriptor
    always_comb begin
        desc       = dump_desc_t'(word[39:0]);
        rmap       = ring_map_t'(word[31:0]);
        desc_reads = desc.mode ? {1'b0, desc.len} : {4'd0, desc.len[14:3]};
    end

endmodule

// File: rtl/regdump_rec_out.sv
// Single-entry record output register with valid/ready handshake and
// accepted-record counter. Assumes push is held until take.
module regdump_rec_out #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [31:0]       in_idx,
    input  logic [63:0]       in_val,
    output logic              take,
    output logic              empty,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [31:0]       rec_idx,
    output logic [63:0]       rec_val,
    output logic [CNT_W-1:0]  rec_count
);

    // Accept a new record when empty or draining this cycle
    always_comb begin
        take  = push && (!rec_valid || rec_ready);
        empty = !rec_valid;
    end

    // Hold or replace the output record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_addr  <= '0;
            rec_idx   <= '0;
            rec_val   <= '0;
        end else if (take) begin
            rec_valid <= 1'b1;
            rec_addr  <= in_addr;
            rec_idx   <= in_idx;
            rec_val   <= in_val;
        end else if (rec_ready) begin
            rec_valid <= 1'b0;
        end
    end

    // Count records accepted downstream
    always_ff @(posedge clk) begin
        if (!rst_n)                      rec_count <= '0;
        else if (clr)                    rec_count <= '0;
        else if (rec_valid && rec_ready) rec_count <= rec_count + CNT_W'(1);
    end

    // R9
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_addr) && $stable(rec_idx) && $stable(rec_val)));

    // R12
    rec_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready) |=> (rec_count == $past(rec_count) + CNT_W'(1)));

endmodule

// File: rtl/regdump_seq_core.sv
// Dump sequencer state machine: pointer read, descriptor chain walk,
// data reads, ring map reads, selector writes and mailbox reads.
// Assumes one outstanding bus request, completed by a one-cycle ack.
module regdump_seq_core
    import regdump_pkg::*;
#(
    parameter int               UID_W      = 4,
    parameter int               UID_SHIFT  = 24,
    parameter int               ADDR_W     = 32,
    parameter int               NUM_RINGS  = 8,
    parameter logic [ADDR_W-1:0] ERRPTR_OFF = 32'h10,
    parameter logic [ADDR_W-1:0] RMAP_BASE  = 32'h100,
    parameter logic [ADDR_W-1:0] SELR_OFF   = 32'h180,
    parameter logic [ADDR_W-1:0] MBX_OFF    = 32'h188
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [UID_W-1:0]  unit_id,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [63:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [63:0]       bus_rdata,
    input  logic              dec_blank,
    input  dump_desc_t        dec_desc,
    input  logic [15:0]       dec_desc_reads,
    input  ring_map_t         dec_rmap,
    output logic              push,
    output logic [ADDR_W-1:0] push_addr,
    output logic [31:0]       push_idx,
    output logic [63:0]       push_val,
    input  logic              push_take,
    input  logic              out_empty,
    output logic              clr_count,
    output logic              busy,
    output logic              done
);

    localparam int RING_W = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1;
    localparam logic [RING_W-1:0] LAST_RING = RING_W'(NUM_RINGS - 1);

    seq_state_t        state;
    logic [ADDR_W-1:0] uoff;
    logic [ADDR_W-1:0] l_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic              rpt_mode;
    logic              from_mbx;
    logic [15:0]       limit;
    logic [15:0]       iter;
    logic [RING_W-1:0] ring;
    logic [7:0]        trace;
    logic [7:0]        traps;
    logic [7:0]        traces;
    logic [15:0]       entries;

    logic [ADDR_W-1:0] uid_off;
    logic [31:0]       cur_sel;
    logic [15:0]       sel_lim;
    logic              ring_last;
    seq_state_t        nt_state;
    logic [7:0]        nt_trace;
    logic [RING_W-1:0] nt_ring;

    // Unit offset, selector, and per-trace read count
    always_comb begin
        uid_off   = ADDR_W'(unit_id) << UID_SHIFT;
        cur_sel   = make_sel(8'(ring), trace);
        sel_lim   = (trace == 8'd0) ? {8'd0, traps} : entries;
        ring_last = (ring == LAST_RING);
    end

    // Step to the next trace, next ring, or finish
    always_comb begin
        nt_state = S_FIN;
        nt_trace = trace;
        nt_ring  = ring;
        if (trace != traces) begin
            nt_state = S_SEL;
            nt_trace = trace + 8'd1;
        end else if (!ring_last) begin
            nt_state = S_RMAP;
            nt_ring  = ring + RING_W'(1);
        end
    end

    // Bus request and address per state
    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            S_PTR:  begin bus_rd = 1'b1; bus_addr = uoff | ERRPTR_OFF; end
            S_DESC: begin bus_rd = 1'b1; bus_addr = l_addr; end
            S_DATA: begin bus_rd = 1'b1; bus_addr = cur_addr; end
            S_RMAP: begin bus_rd = 1'b1; bus_addr = uoff | (RMAP_BASE + (ADDR_W'(ring) << 3)); end
            S_SEL:  begin bus_wr = 1'b1; bus_addr = uoff | SELR_OFF; bus_wdata = 64'(cur_sel); end
            S_MBX:  begin bus_rd = 1'b1; bus_addr = uoff | MBX_OFF; end
            default: ;
        endcase
    end

    // Status and push outputs
    always_comb begin
        busy      = (state != S_IDLE);
        push      = (state == S_PUSH);
        clr_count = start && (state == S_IDLE);
    end

    // Main sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            uoff      <= '0;
            l_addr    <= '0;
            cur_addr  <= '0;
            rpt_mode  <= 1'b0;
            from_mbx  <= 1'b0;
            limit     <= '0;
            iter      <= '0;
            ring      <= '0;
            trace     <= '0;
            traps     <= '0;
            traces    <= '0;
            entries   <= '0;
            push_addr <= '0;
            push_idx  <= '0;
            push_val  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    uoff  <= uid_off;
                    state <= S_PTR;
                end
                S_PTR: if (bus_ack) begin
                    ring <= '0;
                    if (dec_blank) begin
                        state <= S_RMAP;
                    end else begin
                        l_addr <= uoff | ADDR_W'(bus_rdata[UID_SHIFT-1:0]);
                        state  <= S_DESC;
                    end
                end
                S_DESC: if (bus_ack) begin
                    if (dec_blank) begin
                        ring  <= '0;
                        state <= S_RMAP;
                    end else begin
                        l_addr   <= l_addr + ADDR_W'(8);
                        cur_addr <= uoff | ADDR_W'(dec_desc.tgt);
                        rpt_mode <= dec_desc.mode;
                        limit    <= dec_desc_reads;
                        iter     <= '0;
                        if (dec_desc_reads != 16'd0) state <= S_DATA;
                    end
                end
                S_DATA: if (bus_ack) begin
                    push_addr <= cur_addr;
                    push_idx  <= rpt_mode ? 32'(iter) : 32'd0;
                    push_val  <= bus_rdata;
                    from_mbx  <= 1'b0;
                    state     <= S_PUSH;
                end
                S_RMAP: if (bus_ack) begin
                    if (dec_blank) begin
                        if (ring_last) state <= S_FIN;
                        else           ring  <= ring + RING_W'(1);
                    end else begin
                        traps   <= dec_rmap.traps;
                        traces  <= dec_rmap.traces;
                        entries <= dec_rmap.entries;
                        trace   <= '0;
                        state   <= S_SEL;
                    end
                end
                S_SEL: if (bus_ack) begin
                    iter  <= '0;
                    limit <= sel_lim;
                    if (sel_lim != 16'd0) begin
                        state <= S_MBX;
                    end else begin
                        state <= nt_state;
                        trace <= nt_trace;
                        ring  <= nt_ring;
                    end
                end
                S_MBX: if (bus_ack) begin
                    push_addr <= uoff | MBX_OFF;
                    push_idx  <= (cur_sel << 16) | 32'(iter);
                    push_val  <= bus_rdata;
                    from_mbx  <= 1'b1;
                    state     <= S_PUSH;
                end
                S_PUSH: if (push_take) begin
                    if (!from_mbx && !rpt_mode) cur_addr <= cur_addr + ADDR_W'(8);
                    if (iter + 16'd1 == limit) begin
                        if (from_mbx) begin
                            state <= nt_state;
                            trace <= nt_trace;
                            ring  <= nt_ring;
                        end else begin
                            state <= S_DESC;
                        end
                    end else begin
                        iter  <= iter + 16'd1;
                        state <= from_mbx ? S_MBX : S_DATA;
                    end
                end
                S_FIN: if (out_empty) begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R10
    bus_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ack) |=> (bus_rd && $stable(bus_addr)));

    // R10
    bus_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ack) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && out_empty));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/regdump_seq.sv
// Top of the extended error register dump sequencer: wires the word
// decoder, the sequencing core and the record output stage.
// Assumes the bus slave acks each request once.
module regdump_seq #(
    parameter int UID_W     = 4,
    parameter int UID_SHIFT = 24,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 32,
    parameter int NUM_RINGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [UID_W-1:0]  unit_id,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  rec_count,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [63:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [63:0]       bus_rdata,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [31:0]       rec_idx,
    output logic [63:0]       rec_val
);
    import regdump_pkg::*;

    logic              dec_blank;
    dump_desc_t        dec_desc;
    logic [15:0]       dec_desc_reads;
    ring_map_t         dec_rmap;
    logic              push;
    logic [ADDR_W-1:0] push_addr;
    logic [31:0]       push_idx;
    logic [63:0]       push_val;
    logic              push_take;
    logic              out_empty;
    logic              clr_count;

    regdump_decode u_dec (
        .word       (bus_rdata),
        .blank      (dec_blank),
        .desc       (dec_desc),
        .desc_reads (dec_desc_reads),
        .rmap       (dec_rmap)
    );

    regdump_seq_core #(
        .UID_W     (UID_W),
        .UID_SHIFT (UID_SHIFT),
        .ADDR_W    (ADDR_W),
        .NUM_RINGS (NUM_RINGS)
    ) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .unit_id        (unit_id),
        .bus_rd         (bus_rd),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_ack        (bus_ack),
        .bus_rdata      (bus_rdata),
        .dec_blank      (dec_blank),
        .dec_desc       (dec_desc),
        .dec_desc_reads (dec_desc_reads),
        .dec_rmap       (dec_rmap),
        .push           (push),
        .push_addr      (push_addr),
        .push_idx       (push_idx),
        .push_val       (push_val),
        .push_take      (push_take),
        .out_empty      (out_empty),
        .clr_count      (clr_count),
        .busy           (busy),
        .done           (done)
    );

    regdump_rec_out #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_count),
        .push      (push),
        .in_addr   (push_addr),
        .in_idx    (push_idx),
        .in_val    (push_val),
        .take      (push_take),
        .empty     (out_empty),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .rec_addr  (rec_addr),
        .rec_idx   (rec_idx),
        .rec_val   (rec_val),
        .rec_count (rec_count)
    );

endmodule

// File: tb/tb_regdump_seq.sv
`timescale 1ns/1ps
module tb_regdump_seq;

    typedef struct {
        logic [31:0] a;
        logic [31:0] i;
        logic [63:0] v;
    } rec_t;

    typedef struct {
        logic [31:0] a;
        logic [63:0] d;
    } wr_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  unit_id = 4'd0;
    logic        busy, done;
    logic [31:0] rec_count;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_rdata = 64'd0;
    logic        rec_valid;
    logic        rec_ready = 1'b0;
    logic [31:0] rec_addr;
    logic [31:0] rec_idx;
    logic [63:0] rec_val;

    int errors = 0;
    int checks = 0;
    int rdy_mode = 0;
    rec_t exp_q[$];
    wr_t  exp_sel[$];
    logic [31:0] acc_log[$];
    logic [63:0] mem [logic [31:0]];
    logic [15:0] cur_sel = 16'd0;
    logic [15:0] mbx_cnt = 16'd0;

    always #10 clk = ~clk;

    regdump_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .unit_id(unit_id),
        .busy(busy), .done(done), .rec_count(rec_count),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_addr(rec_addr), .rec_idx(rec_idx), .rec_val(rec_val)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic er(input logic [31:0] a, input logic [31:0] i, input logic [63:0] v);
        rec_t r;
        r.a = a; r.i = i; r.v = v;
        exp_q.push_back(r);
    endtask

    task automatic es(input logic [31:0] a, input logic [63:0] d);
        wr_t w;
        w.a = a; w.d = d;
        exp_sel.push_back(w);
    endtask

    function automatic logic [63:0] rdmem(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] mbxv(input logic [15:0] s, input logic [15:0] n);
        return {16'hC0DE, s, 16'h0000, n};
    endfunction

    // Bus slave: variable latency, selector/mailbox side effects
    initial begin
        int wcnt = 0;
        int acc_n = 0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (rst_n && (bus_rd || bus_wr)) begin
                if (wcnt >= acc_n % 3) begin
                    wcnt = 0;
                    acc_n++;
                    acc_log.push_back(bus_addr);
                    if (bus_wr) begin
                        if (exp_sel.size() == 0) begin
                            chk(1'b0, "R7", "unexpected write", 64'(bus_addr), 64'd0);
                        end else begin
                            wr_t w;
                            w = exp_sel.pop_front();
                            chk(bus_addr == w.a, "R7", "selector addr", 64'(bus_addr), 64'(w.a));
                            chk(bus_wdata == w.d, "R7", "selector data", bus_wdata, w.d);
                        end
                        cur_sel = bus_wdata[15:0];
                        mbx_cnt = 16'd0;
                        bus_rdata = 64'd0;
                    end else if (bus_addr[23:0] == 24'h188) begin
                        bus_rdata = mbxv(cur_sel, mbx_cnt);
                        mbx_cnt = mbx_cnt + 16'd1;
                    end else begin
                        bus_rdata = rdmem(bus_addr);
                    end
                    bus_ack = 1'b1;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // Record monitor: ready pattern, scoreboard pop, stall hold check
    initial begin
        int cyc = 0;
        bit stall = 1'b0;
        rec_t h;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n && stall)
                chk(rec_valid && rec_addr == h.a && rec_idx == h.i && rec_val == h.v,
                    "R9", "held record", rec_val, h.v);
            case (rdy_mode)
                0: rec_ready = 1'b1;
                1: rec_ready = (cyc % 3) != 0;
                default: rec_ready = (cyc % 5) < 2;
            endcase
            if (rst_n && rec_valid && rec_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "extra record", 64'(rec_addr), 64'd0);
                end else begin
                    rec_t e;
                    e = exp_q.pop_front();
                    chk(rec_addr == e.a, "R4/R5/R8", "record addr", 64'(rec_addr), 64'(e.a));
                    chk(rec_idx == e.i, "R4/R8", "record idx", 64'(rec_idx), 64'(e.i));
                    chk(rec_val == e.v, "R9", "record val", rec_val, e.v);
                end
            end
            stall = rec_valid && !rec_ready;
            h.a = rec_addr; h.i = rec_idx; h.v = rec_val;
        end
    end

    task automatic run_job(input logic [3:0] uid, input int n_exp, input bit poke);
        int guard = 0;
        acc_log.delete();
        unit_id = uid;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after start", 64'(busy), 64'd1);
        chk(rec_count == 32'd0, "R12", "count cleared", 64'(rec_count), 64'd0);
        if (poke) begin
            repeat (7) @(negedge clk);
            unit_id = 4'hF;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, "R11", "done pulse", 64'(done), 64'd1);
        chk(busy == 1'b0, "R11", "busy low at done", 64'(busy), 64'd0);
        chk(rec_count == 32'(n_exp), "R12", "final count", 64'(rec_count), 64'(n_exp));
        chk(exp_q.size() == 0, "R9", "records missing", 64'(exp_q.size()), 64'd0);
        chk(exp_sel.size() == 0, "R7", "selectors missing", 64'(exp_sel.size()), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", 64'(done), 64'd0);
        chk(rec_count == 32'(n_exp), "R12", "count holds", 64'(rec_count), 64'(n_exp));
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=%h exp=%h", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Main stimulus
    initial begin
        logic [31:0] u1;
        logic [31:0] u2;
        bit seen;
        u1 = 32'h0100_0000;
        u2 = 32'h0200_0000;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(!busy && !done && !rec_valid && !bus_rd && !bus_wr && rec_count == 0,
            "R13", "reset state", {busy, done, rec_valid, bus_rd, bus_wr}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Job 1: unit 1, chain with repeat and sequential, ring 2, ring 5 skipped
        mem[u1 | 32'h10]  = 64'h200;
        mem[u1 | 32'h200] = (64'd1 << 39) | (64'd3 << 24) | 64'h40;
        mem[u1 | 32'h208] = (64'd16 << 24) | 64'h80;
        mem[u1 | 32'h40]  = 64'h1111_2222_3333_4444;
        mem[u1 | 32'h80]  = 64'hAAAA_0000_0000_0080;
        mem[u1 | 32'h88]  = 64'hAAAA_0000_0000_0088;
        mem[u1 | 32'h110] = (64'd2 << 24) | (64'd1 << 16) | 64'd3;
        mem[u1 | 32'h128] = '1;
        // R4 repeat reads
        er(u1 | 32'h40, 32'd0, 64'h1111_2222_3333_4444);
        er(u1 | 32'h40, 32'd1, 64'h1111_2222_3333_4444);
        er(u1 | 32'h40, 32'd2, 64'h1111_2222_3333_4444);
        // R5 sequential reads
        er(u1 | 32'h80, 32'd0, 64'hAAAA_0000_0000_0080);
        er(u1 | 32'h88, 32'd0, 64'hAAAA_0000_0000_0088);
        // R6 R7 R8 ring 2: two traps, one trace of three entries
        es(u1 | 32'h180, 64'h20);
        er(u1 | 32'h188, 32'h0020_0000, mbxv(16'h20, 16'd0));
        er(u1 | 32'h188, 32'h0020_0001, mbxv(16'h20, 16'd1));
        es(u1 | 32'h180, 64'h21);
        er(u1 | 32'h188, 32'h0021_0000, mbxv(16'h21, 16'd0));
        er(u1 | 32'h188, 32'h0021_0001, mbxv(16'h21, 16'd1));
        er(u1 | 32'h188, 32'h0021_0002, mbxv(16'h21, 16'd2));
        rdy_mode = 2;
        run_job(4'd1, 10, 1'b1);
        // R1 first access is the pointer read at the unit offset
        chk(acc_log[0] == (u1 | 32'h10), "R1", "first access", 64'(acc_log[0]), 64'(u1 | 32'h10));
        // R3 chain starts at pointer target
        chk(acc_log[1] == (u1 | 32'h200), "R3", "first descriptor", 64'(acc_log[1]), 64'(u1 | 32'h200));

        // Job 2: unit 0, no chain, ring 0 one trap
        mem[32'h100] = (64'd1 << 24) | 64'd5;
        es(32'h180, 64'h00);
        er(32'h188, 32'h0000_0000, mbxv(16'h00, 16'd0));
        rdy_mode = 0;
        run_job(4'd0, 1, 1'b0);
        // R2 blank pointer goes straight to ring 0 map
        chk(acc_log[1] == 32'h100, "R2", "ring map after blank pointer", 64'(acc_log[1]), 64'h100);

        // Job 3: unit 2, short sequential (no reads), repeat of one, zero traps
        mem[u2 | 32'h10]  = 64'h300;
        mem[u2 | 32'h300] = (64'd7 << 24) | 64'h500;
        mem[u2 | 32'h308] = (64'd1 << 39) | (64'd1 << 24) | 64'h600;
        mem[u2 | 32'h310] = '1;
        mem[u2 | 32'h600] = 64'h600D;
        mem[u2 | 32'h108] = (64'd0 << 24) | (64'd2 << 16) | 64'd1;
        mem[u2 | 32'h138] = '1;
        er(u2 | 32'h600, 32'd0, 64'h600D);
        es(u2 | 32'h180, 64'h10);
        es(u2 | 32'h180, 64'h11);
        er(u2 | 32'h188, 32'h0011_0000, mbxv(16'h11, 16'd0));
        es(u2 | 32'h180, 64'h12);
        er(u2 | 32'h188, 32'h0012_0000, mbxv(16'h12, 16'd0));
        rdy_mode = 1;
        run_job(4'd2, 3, 1'b0);
        // R5 length below 8 bytes reads nothing
        seen = 1'b0;
        foreach (acc_log[k]) if (acc_log[k] == (u2 | 32'h500)) seen = 1'b1;
        chk(!seen, "R5", "no read for short length", 64'(seen), 64'd0);
        // R3 descriptor step of 8
        chk(acc_log[2] == (u2 | 32'h308), "R3", "second descriptor", 64'(acc_log[2]), 64'(u2 | 32'h308));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule